// File: doc/BRIEF.md
# Serial Character Transmitter with Run-Time Framing

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A host writes a character into a one-entry holding register. The block moves it into a shift stage and sends a low start bit, then the data bits least significant first, an optional parity bit, and one or two high stop bits. Every bit lasts sixteen pulses of an external baud tick, which is a one-clock-wide strobe at sixteen times the bit rate.

The frame layout comes from a six-bit line control field. Its two lowest bits give the character length, from five to eight bits. Further bits choose the stop count, turn parity on and choose its sense. One bit forces the line low for a break. The framing fields are captured when a frame starts. The break bit acts on the line at once and does not halt the frame timing running beneath it.

The host watches `hold_empty` to see when it may write again. A character written while a frame is on the line waits in the holding register and is sent straight after the current frame ends.

Top module: `uart_tx_framer`

## Requirements
- R1: While no frame is in progress and break is clear, `ser_out` is 1. A synchronous reset (`rst_n` low at a clock edge) returns the block to that state, with `ser_out` = 1 and `hold_empty` = 1.
- R2: Each frame opens with exactly one start bit at 0. The data bits follow, least significant bit first.
- R3: `line_ctrl[1:0]` sets the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Bits of `hold_data` above that length are never sent.
- R4: When `line_ctrl[3]` = 1, one parity bit goes out between the last data bit and the first stop bit. When it is 0, no parity bit is sent.
- R5: `line_ctrl[4]` = 1 picks even parity, so the ones in data plus parity add up to an even count. `line_ctrl[4]` = 0 picks odd parity.
- R6: `line_ctrl[2]` = 0 sends one stop bit at 1, and `line_ctrl[2]` = 1 sends two.
- R7: Each start, data, parity and stop bit is held for exactly 16 `baud_tick` pulses. During a frame, `ser_out` changes only in the clock after a tick or after a change of the break bit.
- R8: While `line_ctrl[5]` = 1, `ser_out` is 0 from the next clock on. This holds in idle and in the middle of a frame. Clearing the bit gives the line back to the frame in progress, or to idle, on the next clock.
- R9: `hold_empty` goes to 0 in the clock after `hold_wr`. It returns to 1 once the shift stage has taken the character. A character written during a frame starts its own frame right after the current frame's last stop bit, with only a single clock between them.
- R10: Word length, stop count and parity settings are sampled when a frame starts. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-clock strobe at sixteen times the bit rate |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | 8 | Character to send, LSB first on the line |
| line_ctrl | input | 6 | Framing: [1:0] length, [2] stop count, [3] parity enable, [4] even parity, [5] break |
| hold_empty | output | 1 | High when the holding register can take a character |
| ser_out | output | 1 | Serial line, idles high |

## Verification
A wrong frame state shows up on `ser_out` within one bit time, which is sixteen ticks. A missing or extra data bit, parity bit or stop bit moves every later bit of the frame. That makes the next sample the bench takes wrong, and at the latest the start bit of the buffered follower arrives early or late. A holding register whose full flag is wrong shows on `hold_empty` in the very next clock. A shift stage that fails to pick up a waiting character shows as the line staying high where a start bit is due. A fault in the break path shows one clock after the control bit changes.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the serial character transmitter.
// Assumes the line control field is six bits wide with framing fields at
// fixed positions, and characters of at most eight bits.
package uart_tx_pkg;

    localparam int CTRL_W       = 6;
    localparam int CTRL_LEN_LO  = 0;
    localparam int CTRL_STOP2   = 2;
    localparam int CTRL_PAR_EN  = 3;
    localparam int CTRL_PAR_EVN = 4;
    localparam int CTRL_BREAK   = 5;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
    } tx_fmt_t;

    // Unpack the framing fields of the line control value.
    function automatic tx_fmt_t decode_ctrl(input logic [CTRL_W-1:0] c);
        tx_fmt_t f;
        f.nbits    = 4'd5 + {2'b00, c[CTRL_LEN_LO+1:CTRL_LEN_LO]};
        f.two_stop = c[CTRL_STOP2];
        f.par_en   = c[CTRL_PAR_EN];
        f.par_even = c[CTRL_PAR_EVN];
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_holdreg.sv
// One-entry holding register between the host and the shift stage.
// A write always lands and sets the full flag. A take from the shift
// stage clears it unless a write arrives in the same cycle.
// Assumes a synchronous active-low reset.
module uart_tx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic [DATA_W-1:0] rdata,
    output logic              full
);

    // Capture host data and track whether the entry is occupied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            full  <= 1'b0;
        end else if (wr) begin
            rdata <= wdata;
            full  <= 1'b1;
        end else if (take) begin
            full  <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_tx_tickdiv.sv
// Counts baud ticks within one bit cell and flags the tick that ends it.
// A restart clears the count so that a new frame begins on a cell edge.
// Assumes OVERSAMPLE >= 2 and one-clock-wide tick pulses.
module uart_tx_tickdiv #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic bit_done
);

    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] cnt;

    // Advance the in-cell tick count, wrapping at the cell length.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_done = tick && (cnt == LAST);

endmodule

// File: rtl/uart_tx_shifter.sv
// Frame sequencer: start bit, data LSB first, optional parity, stop bits.
// It loads the waiting character and the framing at frame start, masks
// the data to the selected length and precomputes the parity bit.
// Assumes bit_done pulses once per bit cell and DATA_W >= 8.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              avail,
    input  logic [DATA_W-1:0] din,
    input  tx_fmt_t           fmt,
    input  logic              bit_done,
    output logic              take,
    output logic              busy,
    output logic              line_bit
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    tx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bits_left;
    logic              par_q;
    logic              two_stop_q;
    logic              par_en_q;
    logic              second_stop;
    logic [DATA_W-1:0] masked;
    logic              par_next;

    assign take = (state == TX_IDLE) && avail;
    assign busy = (state != TX_IDLE);

    // Clear the data bits beyond the selected length and form the parity.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = din[i] & (i < int'(fmt.nbits));
        end
        par_next = fmt.par_even ? (^masked) : ~(^masked);
    end

    // Step through the frame one bit cell at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= TX_IDLE;
            shreg       <= '0;
            bits_left   <= '0;
            par_q       <= 1'b0;
            two_stop_q  <= 1'b0;
            par_en_q    <= 1'b0;
            second_stop <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (take) begin
                        shreg       <= masked;
                        bits_left   <= CNT_W'(fmt.nbits);
                        par_q       <= par_next;
                        two_stop_q  <= fmt.two_stop;
                        par_en_q    <= fmt.par_en;
                        second_stop <= 1'b0;
                        state       <= TX_START;
                    end
                end
                TX_START: begin
                    if (bit_done) state <= TX_DATA;
                end
                TX_DATA: begin
                    if (bit_done) begin
                        shreg     <= shreg >> 1;
                        bits_left <= bits_left - 1'b1;
                        if (bits_left == CNT_W'(1)) begin
                            state <= par_en_q ? TX_PARITY : TX_STOP;
                        end
                    end
                end
                TX_PARITY: begin
                    if (bit_done) state <= TX_STOP;
                end
                TX_STOP: begin
                    if (bit_done) begin
                        if (two_stop_q && !second_stop) begin
                            second_stop <= 1'b1;
                        end else begin
                            state <= TX_IDLE;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // Select the line level that belongs to the current bit cell.
    always_comb begin
        case (state)
            TX_START:  line_bit = 1'b0;
            TX_DATA:   line_bit = shreg[0];
            TX_PARITY: line_bit = par_q;
            default:   line_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_framer.sv
// Top of the serial character transmitter. It ties together the holding
// register, the bit-cell tick counter and the frame sequencer, and drives
// a registered serial output on which the break bit takes priority.
// Assumes baud_tick is a one-clock strobe at OVERSAMPLE times the bit rate.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [CTRL_W-1:0] line_ctrl,
    output logic              hold_empty,
    output logic              ser_out
);

    tx_fmt_t           fmt;
    logic [DATA_W-1:0] hold_q;
    logic              hold_full;
    logic              take;
    logic              bit_done;
    logic              tx_busy;
    logic              line_bit;
    logic              ser_q;

    assign fmt        = decode_ctrl(line_ctrl);
    assign hold_empty = ~hold_full;
    assign ser_out    = ser_q;

    uart_tx_holdreg #(.DATA_W(DATA_W)) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (hold_wr),
        .wdata (hold_data),
        .take  (take),
        .rdata (hold_q),
        .full  (hold_full)
    );

    uart_tx_tickdiv #(.OVERSAMPLE(OVERSAMPLE)) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (take),
        .tick     (baud_tick),
        .bit_done (bit_done)
    );

    uart_tx_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .avail    (hold_full),
        .din      (hold_q),
        .fmt      (fmt),
        .bit_done (bit_done),
        .take     (take),
        .busy     (tx_busy),
        .line_bit (line_bit)
    );

    // Register the line level, with break forcing it low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q <= 1'b1;
        end else begin
            ser_q <= line_ctrl[CTRL_BREAK] ? 1'b0 : line_bit;
        end
    end

endmodule

// File: rtl/uart_tx_framer_chk.sv
// Property checker for the serial character transmitter, bound to the top.
// It observes the ports plus the sequencer's busy flag.
module uart_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic hold_wr,
    input logic brk,
    input logic hold_empty,
    input logic ser_out,
    input logic busy
);

    // R1: idle with break clear gives a high line in the next cycle
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk) |=> ser_out);

    // R2: the first cell of a frame puts a low start bit on the line
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> !ser_out);

    // R7: inside a frame the line holds still between ticks
    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(baud_tick) && !brk && !$past(brk))
        |=> $stable(ser_out));

    // R8: break drives the line low one clock later
    a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !ser_out);

    // R9: a write makes the holding register report full
    a_r9_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |=> !hold_empty);

    // R9: a waiting character starts a frame without delay when idle
    a_r9_idle_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && !busy) |=> busy);

endmodule

bind uart_tx_framer uart_tx_framer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .hold_wr    (hold_wr),
    .brk        (line_ctrl[5]),
    .hold_empty (hold_empty),
    .ser_out    (ser_out),
    .busy       (tx_busy)
);

// File: tb/uart_tx_framer_tb_top.sv
`timescale 1ns/1ps
module uart_tx_framer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       hold_wr = 1'b0;
    logic [7:0] hold_data = 8'h00;
    logic [5:0] line_ctrl = 6'h03;
    logic       hold_empty;
    logic       ser_out;

    int errors = 0;
    int checks = 0;
    int tick_div = 0;

    // Stimulus table: {character, line control}
    localparam logic [15:0] VECS [0:11] = '{
        {8'hA5, 8'h03}, {8'h3C, 8'h00}, {8'hFF, 8'h01}, {8'h00, 8'h02},
        {8'h81, 8'h07}, {8'h5A, 8'h0B}, {8'hC3, 8'h1B}, {8'h17, 8'h08},
        {8'hE8, 8'h18}, {8'h7E, 8'h1E}, {8'h96, 8'h0C}, {8'h01, 8'h1F}
    };

    uart_tx_framer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .hold_wr    (hold_wr),
        .hold_data  (hold_data),
        .line_ctrl  (line_ctrl),
        .hold_empty (hold_empty),
        .ser_out    (ser_out)
    );

    always #10 clk = ~clk;

    // Baud tick once every three clocks, changed away from the active edge.
    always @(negedge clk) begin
        tick_div  <= (tick_div == 2) ? 0 : tick_div + 1;
        baud_tick <= (tick_div == 2);
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            while (!baud_tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic write_hold(input logic [7:0] d);
        @(negedge clk);
        hold_data = d;
        hold_wr   = 1'b1;
        @(negedge clk);
        hold_wr   = 1'b0;
    endtask

    task automatic wait_fall();
        while (ser_out !== 1'b0) @(negedge clk);
    endtask

    function automatic logic exp_parity(input logic [7:0] d, input logic [5:0] c);
        logic p = 1'b0;
        for (int i = 0; i < 5 + int'(c[1:0]); i++) p ^= d[i];
        return c[4] ? p : ~p;
    endfunction

    task automatic run_frame(input logic [7:0] d, input logic [5:0] c, input bit follow);
        int n;
        n = 5 + int'(c[1:0]);
        line_ctrl = c;
        write_hold(d);
        wait_fall();
        if (follow) begin
            hold_data = 8'h00;
            hold_wr   = 1'b1;
            @(negedge clk);
            hold_wr   = 1'b0;
            check("R9 hold_empty low while buffered", hold_empty, 1'b0);
        end
        wait_ticks(8);
        check("R2 start bit", ser_out, 1'b0);
        for (int i = 0; i < n; i++) begin
            wait_ticks(16);
            check("R3 data bit", ser_out, d[i]);
        end
        if (c[3]) begin
            wait_ticks(16);
            check("R4 R5 parity bit", ser_out, exp_parity(d, c));
        end
        wait_ticks(16);
        check("R6 first stop", ser_out, 1'b1);
        if (c[2]) begin
            wait_ticks(16);
            check("R6 second stop", ser_out, 1'b1);
        end
        wait_ticks(16);
        if (follow) begin
            check("R9 buffered frame follows", ser_out, 1'b0);
            wait_ticks(16 * 13);
        end
        check("R1 idle high after frame", ser_out, 1'b1);
        check("R1 ready after frame", hold_empty, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ser_out", ser_out, 1'b1);
        check("R1 reset hold_empty", hold_empty, 1'b1);

        // Table walk
        for (int v = 0; v < 12; v++) begin
            run_frame(VECS[v][15:8], VECS[v][5:0], (v % 2) == 0);
        end

        // R10: framing change mid-frame does not touch the frame in flight
        line_ctrl = 6'h03;
        write_hold(8'hA5);
        wait_fall();
        line_ctrl = 6'h08;
        wait_ticks(8);
        check("R10 start", ser_out, 1'b0);
        for (int i = 0; i < 8; i++) begin
            wait_ticks(16);
            check("R10 data bit", ser_out, (8'hA5 >> i) & 8'h01);
        end
        wait_ticks(16);
        check("R10 stop without parity", ser_out, 1'b1);
        wait_ticks(16);
        check("R10 idle after one stop", ser_out, 1'b1);

        // R7: start cell length in ticks
        line_ctrl = 6'h03;
        write_hold(8'h01);
        wait_fall();
        wait_ticks(14);
        check("R7 start held 14 ticks", ser_out, 1'b0);
        wait_ticks(3);
        check("R7 data bit after 16 ticks", ser_out, 1'b1);
        wait_ticks(16 * 10);

        // R8: break in idle and in mid-frame
        line_ctrl = 6'h23;
        @(negedge clk);
        @(negedge clk);
        check("R8 break in idle", ser_out, 1'b0);
        check("R8 break leaves ready", hold_empty, 1'b1);
        line_ctrl = 6'h03;
        @(negedge clk);
        @(negedge clk);
        check("R8 release to idle", ser_out, 1'b1);
        write_hold(8'hFF);
        wait_fall();
        wait_ticks(24);
        line_ctrl = 6'h23;
        @(negedge clk);
        @(negedge clk);
        check("R8 break mid-frame", ser_out, 1'b0);
        line_ctrl = 6'h03;
        @(negedge clk);
        @(negedge clk);
        check("R8 release mid-frame", ser_out, 1'b1);
        wait_ticks(16 * 12);

        // R1: reset during a frame
        write_hold(8'h00);
        wait_fall();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-frame ser_out", ser_out, 1'b1);
        check("R1 reset mid-frame hold_empty", hold_empty, 1'b1);
        rst_n = 1'b1;
        wait_ticks(40);
        check("R1 stays idle after reset", ser_out, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule